// File: doc/BRIEF.md
# Strobed Serial Configuration Port

This block receives configuration words over three wires: a serial data line, a serial clock and a strobe. On every falling edge of the serial clock one data bit enters a 16-bit shift register, least significant bit first. On a rising edge of the strobe, the word now in the shift register is copied into one of three holding registers. Only the last sixteen bits shifted before the strobe count. Shifting goes on at all times, whatever the mode and whether writes are locked out.

A sleep input chooses the mode. While sleep is low, the port is in setup mode and the driver outputs are put in high impedance. In this mode the level of the data line at the strobe edge picks the target: low selects the setup register and high selects the extended-setup register. While sleep is high, a strobe edge writes the drive-control register. A ready input comes from an external reset-delay timer. After system reset, and whenever ready is low, every write is locked out and the drivers are held in high impedance. Writes are accepted again only once ready has gone from low to high.

All pins are sampled in one system clock domain through synchronizers before edge detection. The only exception is the high-impedance enable, which follows the raw sleep pin with no delay.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, all three holding registers read zero and `out_hiz_o` is 1.
- R2: On each falling edge of `ser_clk_i`, the level of `ser_dat_i` enters the shift register at bit 15 while the other bits move one place toward bit 0. After 16 falling edges, the first bit sent is bit 0. Rising edges of the serial clock shift nothing.
- R3: When more than 16 bits are shifted before a strobe, only the last 16 bits reach the target register.
- R4: Only a rising edge of `ser_stb_i` writes a register. Holding the strobe high while bits are shifted writes nothing.
- R5: With `sleep_n_i` low, a strobe rising edge writes `setup_o` if `ser_dat_i` is 0 and `ext_setup_o` if `ser_dat_i` is 1. The other two registers are unchanged.
- R6: With `sleep_n_i` high, a strobe rising edge writes `drive_o`. `setup_o` and `ext_setup_o` are unchanged.
- R7: Bits shifted while in either mode, or while writes are locked, stay in the shift register and are used by the next accepted strobe.
- R8: After reset, strobes write nothing until `ready_i` has been seen low and then high. This holds even if `ready_i` is already high when reset ends.
- R9: A low level on `ready_i` locks writes again, and the holding registers keep their values.
- R10: `out_hiz_o` is 1 whenever `sleep_n_i` is low, with no clock delay. It is also 1 while writes are locked, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is captured on its falling edge |
| ser_dat_i | input | 1 | Serial data; also selects the setup target at the strobe |
| ser_stb_i | input | 1 | Strobe; its rising edge latches the shifted word |
| sleep_n_i | input | 1 | Low: setup mode with drivers off; high: drive mode |
| ready_i | input | 1 | Reset-delay indication; writes need a low-to-high transition |
| setup_o | output | 16 | Setup register |
| ext_setup_o | output | 16 | Extended-setup register |
| drive_o | output | 16 | Drive-control register |
| out_hiz_o | output | 1 | High-impedance enable for the driver outputs |

## Verification
The hardest situation to reach is a word shifted in while writes are locked and then committed by a strobe after the lockout ends, with no further bits in between. A second hard case is a strobe that is already high while the word is shifted. The stimulus reaches the first case by shifting during lockout, cycling `ready_i` low and then high, and strobing at once. It reaches the second by raising the strobe before the first bit and releasing it only after the last bit. Random rounds also mix odd bit counts of 16 to 20 with random mode and select levels, so stale bits must be pushed out of the register.

// File: rtl/cfgp_pkg.sv
// Shared width and write-target encoding for the serial configuration port.
// Assumes one configuration word width for all holding registers.
package cfgp_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_SETUP = 2'd1,
        TGT_EXT   = 2'd2,
        TGT_DRIVE = 2'd3
    } tgt_e;
endpackage

// File: rtl/cfgp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes each bit is independent; STAGES >= 1; RST_VAL is the idle level per bit.
module cfgp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: move the sample one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= d;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfgp_edge.sv
// One-cycle pulse on a chosen edge of a synchronized signal.
// RISE=1 detects low-to-high, RISE=0 detects high-to-low. The input must already be synchronous.
module cfgp_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic pulse
);
    logic prev_q;

    // Purpose: remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= d;
    end

    generate
        if (RISE) begin : g_rise
            assign pulse = d & ~prev_q;
        end else begin : g_fall
            assign pulse = ~d & prev_q;
        end
    endgenerate
endmodule

// File: rtl/cfgp_shift.sv
// LSB-first serial-in shift register: a new bit enters at the top and moves toward bit 0.
// Assumes en is a single-cycle pulse per serial clock edge.
module cfgp_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    // Purpose: take one bit in on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)  word_o <= '0;
        else if (en) word_o <= {bit_i, word_o[W-1:1]};
    end
endmodule

// File: rtl/cfgp_regbank.sv
// Three holding registers, written with the shifted word according to a decoded target.
// Assumes the target is TGT_NONE on every cycle with no accepted strobe.
module cfgp_regbank
    import cfgp_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  tgt_e         tgt,
    input  logic [W-1:0] word,
    output logic [W-1:0] setup_q,
    output logic [W-1:0] ext_q,
    output logic [W-1:0] drive_q
);
    // Purpose: update only the register named by the target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= '0;
            ext_q   <= '0;
            drive_q <= '0;
        end else begin
            case (tgt)
                TGT_SETUP: setup_q <= word;
                TGT_EXT:   ext_q   <= word;
                TGT_DRIVE: drive_q <= word;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/serial_cfg_port.sv
// Top of the strobed serial configuration port.
// Syncs the pins, detects serial clock falls and strobe rises, shifts LSB first,
// and routes strobed words by mode. Writes stay locked until ready goes low then high.
// Assumes the serial pins change slower than SYNC_STAGES+1 system clocks.
module serial_cfg_port
    import cfgp_pkg::*;
#(
    parameter int W           = WORD_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk_i,
    input  logic         ser_dat_i,
    input  logic         ser_stb_i,
    input  logic         sleep_n_i,
    input  logic         ready_i,
    output logic [W-1:0] setup_o,
    output logic [W-1:0] ext_setup_o,
    output logic [W-1:0] drive_o,
    output logic         out_hiz_o
);
    localparam int PIN_N = 4;
    localparam int P_CLK = 0, P_DAT = 1, P_STB = 2, P_SLP = 3;

    logic [PIN_N-1:0] pin_s;
    logic             ready_s;
    logic             clk_fall, stb_rise;
    logic             sleep_s;
    logic             armed_q, lock_q;
    logic [W-1:0]     shift_word;
    tgt_e             tgt;

    cfgp_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sleep_n_i, ser_stb_i, ser_dat_i, ser_clk_i}),
        .q(pin_s)
    );

    cfgp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ready_sync (
        .clk(clk), .rst_n(rst_n), .d(ready_i), .q(ready_s)
    );

    cfgp_edge #(.RISE(1'b0)) u_clk_edge (
        .clk(clk), .rst_n(rst_n), .d(pin_s[P_CLK]), .pulse(clk_fall)
    );

    cfgp_edge #(.RISE(1'b1)) u_stb_edge (
        .clk(clk), .rst_n(rst_n), .d(pin_s[P_STB]), .pulse(stb_rise)
    );

    cfgp_shift #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .en(clk_fall),
        .bit_i(pin_s[P_DAT]), .word_o(shift_word)
    );

    assign sleep_s = pin_s[P_SLP];

    // Purpose: lockout tracking; a low ready arms and locks, a later high ready unlocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            lock_q  <= 1'b1;
        end else if (!ready_s) begin
            armed_q <= 1'b1;
            lock_q  <= 1'b1;
        end else if (armed_q) begin
            lock_q  <= 1'b0;
        end
    end

    // Purpose: choose the write target from mode and data level at the strobe edge.
    always_comb begin
        tgt = TGT_NONE;
        if (stb_rise && !lock_q) begin
            if (sleep_s)               tgt = TGT_DRIVE;
            else if (pin_s[P_DAT])     tgt = TGT_EXT;
            else                       tgt = TGT_SETUP;
        end
    end

    cfgp_regbank #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .tgt(tgt), .word(shift_word),
        .setup_q(setup_o), .ext_q(ext_setup_o), .drive_q(drive_o)
    );

    assign out_hiz_o = ~sleep_n_i | lock_q;
endmodule

// File: rtl/cfgp_chk.sv
// Checker for serial_cfg_port, bound into every instance.
// Assumes the internal lock and synchronized sleep signals are connected by the bind.
module cfgp_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sleep_n_i,
    input logic         out_hiz_o,
    input logic [W-1:0] setup_o,
    input logic [W-1:0] ext_setup_o,
    input logic [W-1:0] drive_o,
    input logic         lock_q,
    input logic         sleep_s
);
    p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> ($stable(setup_o) && $stable(ext_setup_o) && $stable(drive_o)));

    p_relock_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lock_q)) |-> ($stable(setup_o) && $stable(ext_setup_o) && $stable(drive_o)));

    p_sleep_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_s |=> $stable(drive_o));

    p_awake_no_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_s |=> ($stable(setup_o) && $stable(ext_setup_o)));

    p_one_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({setup_o != $past(setup_o), ext_setup_o != $past(ext_setup_o),
                    drive_o != $past(drive_o)}) <= 1);

    p_hiz_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n_i |-> out_hiz_o);
endmodule

bind serial_cfg_port cfgp_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_n_i(sleep_n_i), .out_hiz_o(out_hiz_o),
    .setup_o(setup_o), .ext_setup_o(ext_setup_o), .drive_o(drive_o),
    .lock_q(lock_q), .sleep_s(sleep_s)
);

// File: tb/serial_cfg_port_tb.sv
module serial_cfg_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int GAP        = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ser_clk_i, ser_dat_i, ser_stb_i, sleep_n_i, ready_i;
    logic [W-1:0] setup_o, ext_setup_o, drive_o;
    logic         out_hiz_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [W-1:0] m_sh, m_setup, m_ext, m_drive;

    serial_cfg_port u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
        .ser_stb_i(ser_stb_i), .sleep_n_i(sleep_n_i), .ready_i(ready_i),
        .setup_o(setup_o), .ext_setup_o(ext_setup_o), .drive_o(drive_o),
        .out_hiz_o(out_hiz_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] shift_in(logic [W-1:0] sh, logic b);
        return {b, sh[W-1:1]};
    endfunction

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        check({req, " setup"}, setup_o, m_setup);
        check({req, " ext"},   ext_setup_o, m_ext);
        check({req, " drive"}, drive_o, m_drive);
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = 0; i < n; i++) begin
            ser_dat_i = v[i];
            wait_cyc(GAP);
            ser_clk_i = 1'b0;
            wait_cyc(GAP);
            ser_clk_i = 1'b1;
            wait_cyc(GAP);
            m_sh = shift_in(m_sh, v[i]);
        end
    endtask

    // strobe with the given data level; model applies when accepted
    task automatic strobe(logic sel, bit accepted);
        ser_dat_i = sel;
        wait_cyc(GAP);
        ser_stb_i = 1'b1;
        wait_cyc(GAP + 3);
        ser_stb_i = 1'b0;
        wait_cyc(GAP);
        if (accepted) begin
            if (sleep_n_i)  m_drive = m_sh;
            else if (sel)   m_ext   = m_sh;
            else            m_setup = m_sh;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ser_clk_i = 1'b1; ser_dat_i = 1'b0; ser_stb_i = 1'b0;
        sleep_n_i = 1'b0; ready_i = 1'b1;
        m_sh = '0; m_setup = '0; m_ext = '0; m_drive = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(GAP);

        // R1 reset state
        check_regs("R1");
        check("R1 hiz", W'(out_hiz_o), W'(1));

        // R8 ready high from reset: still locked
        send_bits(32'hA5C3, 16);
        strobe(1'b0, 1'b0);
        check_regs("R8 locked");
        check("R10 locked hiz", W'(out_hiz_o), W'(1));

        // R8 low then high unlocks; R7 bits shifted while locked are kept
        ready_i = 1'b0; wait_cyc(GAP);
        ready_i = 1'b1; wait_cyc(GAP);
        strobe(1'b0, 1'b1);
        check_regs("R7 R8 unlock");

        // R5 extended setup select
        send_bits(32'h1234, 16);
        strobe(1'b1, 1'b1);
        check_regs("R5 ext");

        // R6 drive mode, R10 hiz released
        sleep_n_i = 1'b1; wait_cyc(GAP);
        check("R10 awake hiz", W'(out_hiz_o), W'(0));
        send_bits(32'hBEEF, 16);
        strobe(1'b0, 1'b1);
        check_regs("R6 drive");

        // R2 LSB first
        send_bits(32'h0001, 16);
        strobe(1'b1, 1'b1);
        check_regs("R2 lsb");

        // R4 strobe held high during shifting writes nothing
        ser_stb_i = 1'b1; wait_cyc(GAP);
        send_bits(32'h0F0F, 16);
        check_regs("R4 level");
        ser_stb_i = 1'b0; wait_cyc(GAP);
        strobe(1'b0, 1'b1);
        check_regs("R4 edge");

        // R3 twenty bits, last sixteen kept
        send_bits(32'h000C_3579, 20);
        strobe(1'b0, 1'b1);
        check_regs("R3 overlong");

        // R9 relock keeps registers
        ready_i = 1'b0; wait_cyc(GAP);
        check("R9 hiz", W'(out_hiz_o), W'(1));
        send_bits(32'h7777, 16);
        strobe(1'b0, 1'b0);
        check_regs("R9 relocked");
        ready_i = 1'b1; wait_cyc(GAP);

        // R10 immediate hiz on sleep low
        sleep_n_i = 1'b0;
        #1;
        check("R10 immediate", W'(out_hiz_o), W'(1));
        wait_cyc(GAP);

        // random rounds across modes and bit counts (R2 R3 R5 R6 R7)
        void'($urandom(32'd1234));
        for (int k = 0; k < 40; k++) begin
            logic [31:0] v;
            int          n;
            logic        sel;
            v   = $urandom;
            n   = 16 + int'($urandom % 5);
            sel = 1'($urandom);
            sleep_n_i = 1'($urandom);
            wait_cyc(GAP);
            send_bits(v, n);
            strobe(sel, 1'b1);
            check_regs("R5 R6 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule